// File: doc/BRIEF.md
# Two-Way Cache with Per-Block Fault Deletion

This block is a small two-way set-associative, write-through cache placed between a processor request port and a word-wide memory port. Every cache block owns a fault flag. A flagged block takes no part in lookup and is never picked as a replacement target, so each flagged block lowers its set's associativity by one. When both blocks of a set are flagged, the set has no storage left. Every load or store that indexes it then goes straight to memory as an uncached access and nothing is allocated.

Fault flags are loaded through a serial configuration port. Each shift rewrites the flag chain, so every shift also invalidates all lines and re-aims every set's replacement pointer at a healthy way. Stores always go to memory. A store miss in a set that still has a healthy way allocates a line holding the stored word. Replacement is least-recently-used among the healthy ways of a set. Free healthy ways are filled before any line is evicted.

The controller is a five-state machine:
- ST_IDLE takes a request (the accept transition) to ST_LOOKUP.
- From ST_LOOKUP, a read hit goes to ST_REPLY, a read miss or a read of a dead set goes to ST_FETCH, and any store goes to ST_STORE.
- ST_FETCH and ST_STORE wait for the memory acknowledge and then go to ST_REPLY.
- ST_REPLY pulses the done output and returns to ST_IDLE.

Top module: `bdc_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_done and mem_req are 0, no fault flag is set and every line is invalid, so the first read of any address misses.
- R2: A read that hits returns the stored word with resp_hit=1 and makes no memory transaction.
- R3: A read miss in a set with a healthy way makes one memory read and returns its data with resp_hit=0. It fills a healthy way, so a repeat read hits.
- R4: Every store makes exactly one memory write. A store hit updates the line. A store miss in a set with a healthy way allocates the word, so a following read hits with the stored data.
- R5: A flagged block never hits and is never written. With one way of a set flagged, two addresses of that set evict each other on every access.
- R6: With both ways healthy and valid, the victim is the way used less recently. The replacement pointer of a set with a healthy way never names a flagged way.
- R7: When both ways of a set are flagged, every read and store to it makes one memory transaction and reports resp_hit=0. No line is allocated, so a repeat read misses again and returns the current memory word.
- R8: Each cycle with cfg_shift=1 in ST_IDLE shifts cfg_bit into the flag chain at the top. After 16 shifts, the k-th bit shifted in (counting from 0) is the flag of block k, where block k = 2*set + way. Each shift invalidates all lines. While cfg_shift is 1, req_ready is 0.
- R9: A request is accepted only in a cycle with req_valid=1 and req_ready=1. resp_done is a one-cycle pulse. mem_req, once raised, holds with stable address, data and direction until mem_ack.
- R10: Address bits [2:0] select the set and bits [7:3] form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 1 | Shift one fault flag into the chain |
| cfg_bit | input | 1 | Fault flag value shifted in |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 8 | Word address |
| req_wdata | input | 16 | Store data |
| req_ready | output | 1 | Controller can accept a request |
| resp_done | output | 1 | Request finished (one-cycle pulse) |
| resp_hit | output | 1 | Request hit a healthy valid line |
| resp_rdata | output | 16 | Load data |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory transaction complete |
| mem_rdata | input | 16 | Memory read data |

## Verification
The assertions cover several rules on every cycle:
- no line write ever lands in a flagged block, and a dead set never allocates;
- at most one way matches;
- each set's replacement pointer stays on a healthy way;
- the memory request stays stable until acknowledged;
- done is a single pulse;
- a read hit never touches memory.

Only the bench scenarios can show the end-to-end results, checked against a reference model over directed and random fault patterns including fully flagged sets:
- hit and miss outcomes and returned data;
- LRU eviction order;
- flag chain bit order;
- invalidation on configuration.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FETCH,
        ST_STORE,
        ST_REPLY
    } ctl_state_t;
endpackage

// File: rtl/bdc_fault_map.sv
module bdc_fault_map #(
    parameter int NBLK = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            shift_bit,
    output logic [NBLK-1:0] flags,
    output logic [NBLK-1:0] flags_d
);
    // New bit enters at the top; after NBLK shifts the first bit sits at index 0.
    always_comb flags_d = shift_en ? {shift_bit, flags[NBLK-1:1]} : flags;

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end
endmodule

// File: rtl/bdc_way_lookup.sv
module bdc_way_lookup #(
    parameter int TAG_W = 5,
    parameter int WAYS  = 2
) (
    input  logic [WAYS-1:0]       set_valid,
    input  logic [WAYS*TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]       set_fault,
    input  logic                  set_lru,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  hit,
    output logic                  hit_way,
    output logic                  dead,
    output logic                  victim
);
    logic [WAYS-1:0] healthy;
    logic [WAYS-1:0] free_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w]  = set_valid[w] && !set_fault[w] &&
                             (set_tags[w*TAG_W +: TAG_W] == tag);
        assign healthy[w]  = !set_fault[w];
        assign free_way[w] = !set_fault[w] && !set_valid[w];
    end

    always_comb begin
        hit     = |hit_vec;
        hit_way = hit_vec[1];
        dead    = ~|healthy;
        if (free_way[0])     victim = 1'b0;
        else if (free_way[1]) victim = 1'b1;
        else if (!healthy[0]) victim = 1'b1;
        else if (!healthy[1]) victim = 1'b0;
        else                  victim = set_lru;
    end
endmodule

// File: rtl/bdc_lru_store.sv
module bdc_lru_store #(
    parameter int SET_W = 3,
    localparam int SETS = 1 << SET_W,
    localparam int NBLK = 2 * SETS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBLK-1:0]  flags,
    input  logic [NBLK-1:0]  flags_d,
    input  logic             reload,
    input  logic             upd,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_way,
    output logic [SETS-1:0]  lru
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru <= '0;
        end else if (reload) begin
            for (int s = 0; s < SETS; s++) lru[s] <= flags_d[2*s];
        end else if (upd) begin
            lru[upd_set] <= flags[{upd_set, ~upd_way}] ? upd_way : ~upd_way;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        // R6: a set with a healthy way never points its victim at a flagged way
        a_r6_lru_healthy: assert property (@(posedge clk) disable iff (!rst_n)
            !(flags[2*s] && flags[2*s+1]) |-> !flags[2*s + int'(lru[s])]);
    end
endmodule

// File: rtl/bdc_cache.sv
module bdc_cache #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SET_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shift,
    input  logic              cfg_bit,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_done,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import bdc_pkg::*;

    localparam int WAYS  = 2;
    localparam int SETS  = 1 << SET_W;
    localparam int NBLK  = SETS * WAYS;
    localparam int TAG_W = ADDR_W - SET_W;

    ctl_state_t state, state_nx;

    logic              op_we_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              hit_q, bypass_q, vic_q;

    logic [NBLK-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [NBLK];
    logic [DATA_W-1:0] data_q [NBLK];

    logic [NBLK-1:0]   flags, flags_d;
    logic [SETS-1:0]   lru;
    logic              shift_en, accept;

    logic [SET_W-1:0]  set_idx;
    logic [TAG_W-1:0]  op_tag;
    logic [WAYS-1:0]   set_valid, set_fault, hit_vec;
    logic [WAYS*TAG_W-1:0] set_tags;
    logic              hit, hit_way, dead, victim;

    logic              line_we, line_way, lru_upd, lru_way;
    logic [DATA_W-1:0] line_data;

    assign set_idx  = op_addr_q[SET_W-1:0];
    assign op_tag   = op_addr_q[ADDR_W-1:SET_W];
    assign shift_en = cfg_shift && (state == ST_IDLE);
    assign accept   = req_valid && req_ready;

    bdc_fault_map #(.NBLK(NBLK)) u_fault (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_bit(cfg_bit),
        .flags(flags), .flags_d(flags_d)
    );

    bdc_lru_store #(.SET_W(SET_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .flags(flags), .flags_d(flags_d),
        .reload(shift_en), .upd(lru_upd), .upd_set(set_idx), .upd_way(lru_way),
        .lru(lru)
    );

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w]                 = valid_q[{set_idx, 1'(w)}];
            set_fault[w]                 = flags[{set_idx, 1'(w)}];
            set_tags[w*TAG_W +: TAG_W]   = tag_q[{set_idx, 1'(w)}];
        end
    end

    bdc_way_lookup #(.TAG_W(TAG_W), .WAYS(WAYS)) u_look (
        .set_valid(set_valid), .set_tags(set_tags), .set_fault(set_fault),
        .set_lru(lru[set_idx]), .tag(op_tag), .hit_vec(hit_vec), .hit(hit),
        .hit_way(hit_way), .dead(dead), .victim(victim)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_LOOKUP;
            ST_LOOKUP: begin
                if (op_we_q)  state_nx = ST_STORE;
                else if (hit) state_nx = ST_REPLY;
                else          state_nx = ST_FETCH;
            end
            ST_FETCH:  if (mem_ack) state_nx = ST_REPLY;
            ST_STORE:  if (mem_ack) state_nx = ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and line/LRU write controls
    always_comb begin
        req_ready  = (state == ST_IDLE) && !cfg_shift;
        resp_done  = (state == ST_REPLY);
        resp_hit   = hit_q;
        resp_rdata = rdata_q;
        mem_req    = (state == ST_FETCH) || (state == ST_STORE);
        mem_we     = (state == ST_STORE);
        mem_addr   = op_addr_q;
        mem_wdata  = op_wdata_q;
        line_we    = 1'b0;
        line_way   = 1'b0;
        line_data  = op_wdata_q;
        lru_upd    = 1'b0;
        lru_way    = 1'b0;
        unique case (state)
            ST_LOOKUP: begin
                if (hit) begin
                    lru_upd  = 1'b1;
                    lru_way  = hit_way;
                    line_we  = op_we_q;
                    line_way = hit_way;
                end else if (op_we_q && !dead) begin
                    line_we  = 1'b1;
                    line_way = victim;
                    lru_upd  = 1'b1;
                    lru_way  = victim;
                end
            end
            ST_FETCH: begin
                if (mem_ack && !bypass_q) begin
                    line_we   = 1'b1;
                    line_way  = vic_q;
                    line_data = mem_rdata;
                    lru_upd   = 1'b1;
                    lru_way   = vic_q;
                end
            end
            ST_IDLE, ST_STORE, ST_REPLY: ;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= '0;
            op_we_q    <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            rdata_q    <= '0;
            hit_q      <= 1'b0;
            bypass_q   <= 1'b0;
            vic_q      <= 1'b0;
        end else begin
            if (shift_en) valid_q <= '0;
            if (accept) begin
                op_we_q    <= req_we;
                op_addr_q  <= req_addr;
                op_wdata_q <= req_wdata;
            end
            if (state == ST_LOOKUP) begin
                hit_q    <= hit;
                bypass_q <= dead;
                vic_q    <= victim;
                if (hit && !op_we_q) rdata_q <= data_q[{set_idx, hit_way}];
            end
            if (state == ST_FETCH && mem_ack) rdata_q <= mem_rdata;
            if (line_we) begin
                valid_q[{set_idx, line_way}] <= 1'b1;
                tag_q[{set_idx, line_way}]   <= op_tag;
                data_q[{set_idx, line_way}]  <= line_data;
            end
        end
    end

    // R5: no line write ever targets a flagged block
    a_r5_no_fill_faulty: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |-> !flags[{set_idx, line_way}]);
    // R5: at most one way matches a tag
    a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP) |-> $onehot0(hit_vec));
    // R7: a dead set never allocates
    a_r7_dead_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && set_fault == 2'b11) |-> !line_we);
    // R9: memory request held stable until acknowledged
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);
    // R2: a read hit completes without a memory transaction
    a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_hit && !op_we_q) |-> !$past(mem_req));
endmodule

// File: tb/bdc_cache_test.sv
`timescale 1ns/1ps
module bdc_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_shift = 1'b0, cfg_bit = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, resp_done, resp_hit;
    logic [15:0] resp_rdata;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    bdc_cache uut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .resp_done(resp_done),
        .resp_hit(resp_hit), .resp_rdata(resp_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory and reference model
    logic [15:0] mem   [256];
    logic [15:0] rmem  [256];
    bit          mflt  [16];
    bit          mval  [16];
    logic [4:0]  mtag  [16];
    logic [15:0] mdat  [16];
    bit          mlru  [8];
    int          memops = 0, last_ops = 0, n_done = 0, wcnt = 0;

    typedef struct { bit we; bit hit; logic [15:0] rd; int ops; } exp_t;
    exp_t  expq[$];
    string tagq[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (wcnt == 1) begin
                mem_ack = 1'b1;
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata = mem[mem_addr];
                memops++;
                wcnt = 0;
            end else wcnt++;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (resp_done) begin
            if (expq.size() == 0) check(0, "R9", "unexpected done", 1, 0);
            else begin
                exp_t e; string t;
                e = expq.pop_front(); t = tagq.pop_front();
                check(resp_hit == e.hit, t, "hit", resp_hit, e.hit);
                if (!e.we) check(resp_rdata == e.rd, t, "rdata", resp_rdata, e.rd);
                check(memops - last_ops == e.ops, t, "mem ops", memops - last_ops, e.ops);
            end
            last_ops = memops;
            n_done++;
        end
    end

    function automatic void touch(input int s, input int w);
        mlru[s] = mflt[2*s + (1-w)] ? w[0] : ~w[0];
    endfunction

    function automatic exp_t model(input bit we, input logic [7:0] a, input logic [15:0] d);
        exp_t e;
        int s = int'(a[2:0]);
        int b = 2*s;
        int hw = -1, vic;
        bit dead;
        for (int w = 0; w < 2; w++)
            if (mval[b+w] && !mflt[b+w] && mtag[b+w] == a[7:3]) hw = w;
        dead = mflt[b] && mflt[b+1];
        if (!mflt[b] && !mval[b]) vic = 0;
        else if (!mflt[b+1] && !mval[b+1]) vic = 1;
        else if (mflt[b]) vic = 1;
        else if (mflt[b+1]) vic = 0;
        else vic = int'(mlru[s]);
        e.we = we; e.hit = (hw >= 0); e.rd = '0;
        e.ops = (we || hw < 0) ? 1 : 0;
        if (we) rmem[a] = d;
        if (hw >= 0) begin
            if (we) mdat[b+hw] = d;
            e.rd = mdat[b+hw];
            touch(s, hw);
        end else begin
            e.rd = rmem[a];
            if (!dead) begin
                mval[b+vic] = 1; mtag[b+vic] = a[7:3]; mdat[b+vic] = we ? d : rmem[a];
                touch(s, vic);
            end
        end
        return e;
    endfunction

    task automatic do_op(input bit we, input logic [7:0] a, input logic [15:0] d,
                         input string tag);
        int target;
        expq.push_back(model(we, a, d));
        tagq.push_back(tag);
        target = n_done + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        while (n_done < target) @(negedge clk);
    endtask

    task automatic load_faults(input logic [15:0] f);
        @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            cfg_shift = 1; cfg_bit = f[k];
            @(negedge clk);
        end
        cfg_shift = 0;
        for (int k = 0; k < 16; k++) begin mflt[k] = f[k]; mval[k] = 0; end
        for (int s = 0; s < 8; s++) mlru[s] = f[2*s];
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 16'h0123) ^ 16'h5a5a; rmem[i] = mem[i];
        end
        for (int k = 0; k < 16; k++) begin mflt[k] = 0; mval[k] = 0; end
        for (int s = 0; s < 8; s++) mlru[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1, "R1", "ready", req_ready, 1);
        check(resp_done == 0, "R1", "done", resp_done, 0);
        check(mem_req == 0, "R1", "mem_req", mem_req, 0);
        do_op(0, 8'h10, 0, "R1");          // first read misses
        do_op(0, 8'h10, 0, "R2");          // hit
        do_op(1, 8'h10, 16'hbeef, "R4");   // write hit, write-through
        do_op(0, 8'h10, 0, "R2");          // hit, new data
        do_op(1, 8'h21, 16'h1234, "R4");   // write miss allocates
        do_op(0, 8'h21, 0, "R4");
        do_op(0, 8'h45, 0, "R3");
        do_op(0, 8'h45, 0, "R10");         // set 5, tag 8
        // R6 LRU order in set 0
        do_op(0, 8'h00, 0, "R6");
        do_op(0, 8'h08, 0, "R6");
        do_op(0, 8'h00, 0, "R6");
        do_op(0, 8'h18, 0, "R6");          // evicts 0x08
        do_op(0, 8'h00, 0, "R6");          // hit
        do_op(0, 8'h08, 0, "R6");          // miss
        // R8 flag order: set0 way0, set1 both, set2 way1
        load_faults(16'b0000_0000_0010_1101);
        do_op(0, 8'h00, 0, "R8");          // invalidated: miss
        do_op(0, 8'h08, 0, "R5");
        do_op(0, 8'h00, 0, "R5");          // evicted by one-way set
        do_op(0, 8'h12, 0, "R5");
        do_op(0, 8'h1a, 0, "R5");
        do_op(0, 8'h12, 0, "R5");
        do_op(0, 8'h07, 0, "R8");          // set 7 keeps two ways
        do_op(0, 8'h0f, 0, "R8");
        do_op(0, 8'h07, 0, "R8");          // hit
        do_op(0, 8'h01, 0, "R7");
        do_op(0, 8'h01, 0, "R7");          // still bypass
        do_op(1, 8'h09, 16'h7777, "R7");
        do_op(0, 8'h09, 0, "R7");          // miss, memory data
        // random fault patterns
        for (int p = 0; p < 5; p++) begin
            logic [15:0] f;
            f = (p == 0) ? 16'h0000 : (p == 4) ? 16'hffff : 16'($urandom);
            load_faults(f);
            for (int n = 0; n < 120; n++) begin
                logic [7:0] a;
                a = {3'b000, 2'($urandom), 3'($urandom)};
                if ($urandom_range(3) == 0) do_op(1, a, 16'($urandom), "R4");
                else                        do_op(0, a, 0, "R5");
            end
        end
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule